// File: doc/BRIEF.md
# Sequential Unsigned Divider with Selectable Restoring or Non-Restoring Iteration

This block divides an unsigned 2N-bit dividend by an unsigned N-bit divisor. It returns an N-bit quotient and an N-bit remainder after a fixed number of clock cycles. The algorithm is picked for each operation by a one-bit `mode` input. Low selects restoring iteration and high selects non-restoring iteration. Both algorithms run on a single (N+1)-bit add/subtract unit. They operate on a combined partial-remainder:quotient shift register, and every step decides from the sign bit of the partial remainder.

A caller drives `start` for one cycle with the operands on the inputs. From the next cycle `busy` is high until the result is ready. The result then appears on registered outputs together with a one-cycle `done` pulse, and it stays there until the next operation completes. A zero divisor does not start the iteration. It finishes right away and raises a flag. The caller must keep the upper dividend half below the divisor, because quotient overflow is not detected.

Top module: `seq_divider`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.
- R2: In restoring mode (`mode`=0), a start with a nonzero divisor makes `busy` high for N+1 cycles. `done` is high in the cycle after the last busy cycle. The total is N+1 clock edges from the start edge to the `done` edge.
- R3: In non-restoring mode (`mode`=1), the same start makes `busy` high for N+2 cycles. The extra cycle is the final sign correction.
- R4: When the upper dividend half is less than the divisor, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor in both modes. For example, dividend 32 with divisor 6 gives quotient 5 and remainder 2.
- R5: In non-restoring mode the corrective addition leaves the final partial remainder non-negative, so `remainder` is always below the divisor.
- R6: A start with divisor 0 gives `done`=1 and `div_by_zero`=1 one cycle later. In that case `quotient` is all ones, `remainder` equals the low N dividend bits, and `busy` never rises.
- R7: A `start` pulse while `busy` is high is ignored: the running operation completes with its original operands and timing.
- R8: `done` is high for exactly one cycle per completion. `quotient`, `remainder` and `div_by_zero` change only in cycles where `done` is high.
- R9: A completed division with a nonzero divisor clears `div_by_zero`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| mode | input | 1 | 0 = restoring, 1 = non-restoring |
| dividend | input | 2N | Unsigned dividend |
| divisor | input | N | Unsigned divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results update |
| quotient | output | N | Result quotient, held between completions |
| remainder | output | N | Result remainder, held between completions |
| div_by_zero | output | 1 | Last completion had a zero divisor |

## Verification
A corrupted partial remainder or a wrong sign decision shows up as a wrong quotient or remainder at the single `done` edge that ends the operation. The bench reference model predicts that edge exactly, so the error is caught in that same cycle. A miscounted iteration loop, or a correction cycle that is missed or added, moves the `done` edge and the falling edge of `busy`. Since these are compared on every clock, the mismatch is reported within one cycle of the expected completion. A start that wrongly restarts a busy operation changes the operands or the timing, and this appears the same way.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2,
    ST_OUT  = 2'd3
  } dstate_t;

  localparam logic MODE_RESTORE    = 1'b0;
  localparam logic MODE_NONRESTORE = 1'b1;

endpackage

// File: rtl/div_addsub.sv
module div_addsub #(
  parameter int W = 5
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub,
  output logic [W-1:0] res
);

  logic [W-1:0] opb_x;

  // Subtraction is done as addition of the ones-complement plus carry-in.
  always_comb begin
    opb_x = opb ^ {W{sub}};
    res   = opa + opb_x + {{(W-1){1'b0}}, sub};
  end

endmodule

// File: rtl/div_aq_reg.sv
module div_aq_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [N:0]   a_in,
  input  logic [N-1:0] q_in,
  output logic [N:0]   a_out,
  output logic [N-1:0] q_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out <= '0;
      q_out <= '0;
    end else if (ld) begin
      a_out <= a_in;
      q_out <= q_in;
    end
  end

endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int N = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    mode,
  input  logic    dz,
  output dstate_t st,
  output logic    acc,
  output logic    zhit,
  output logic    nr_mode
);

  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;

  always_comb begin
    acc  = (st == ST_IDLE) && start && !dz;
    zhit = (st == ST_IDLE) && start && dz;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      nr_mode <= MODE_RESTORE;
    end else begin
      case (st)
        ST_IDLE: begin
          if (acc) begin
            st      <= ST_RUN;
            cnt     <= '0;
            nr_mode <= mode;
          end
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= nr_mode ? ST_FIX : ST_OUT;
        end
        ST_FIX:  st <= ST_OUT;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: iteration counter never passes the loop count
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |-> (cnt < CW'(N)));

  // R3: correction state is reached only in non-restoring mode
  a_r3_fix_only_nr: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FIX) |-> (nr_mode == MODE_NONRESTORE));

  // R7: a running operation keeps its mode
  a_r7_mode_kept: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> $stable(nr_mode));

endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           mode,
  input  logic [2*N-1:0] dividend,
  input  logic [N-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic [N-1:0]   quotient,
  output logic [N-1:0]   remainder,
  output logic           div_by_zero
);

  localparam int AW = N + 1;

  dstate_t       st;
  logic          acc, zhit, nr, dz;
  logic [N-1:0]  d_r;
  logic [AW-1:0] a, a_sh, opa, opb, sum, a_in;
  logic [N-1:0]  q, q_in;
  logic          sub, aq_ld;

  assign dz = (divisor == '0);

  div_ctrl #(.N(N)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .dz(dz),
    .st(st), .acc(acc), .zhit(zhit), .nr_mode(nr)
  );

  div_aq_reg #(.N(N)) aq_i (
    .clk(clk), .rst(rst), .ld(aq_ld), .a_in(a_in), .q_in(q_in),
    .a_out(a), .q_out(q)
  );

  div_addsub #(.W(AW)) alu_i (
    .opa(opa), .opb(opb), .sub(sub), .res(sum)
  );

  // Divisor capture
  always_ff @(posedge clk) begin
    if (rst)      d_r <= '0;
    else if (acc) d_r <= divisor;
  end

  // Operand selection for the shared adder
  always_comb begin
    a_sh = {a[N-1:0], q[N-1]};
    opb  = {1'b0, d_r};
    if (st == ST_FIX) begin
      opa = a;
      sub = 1'b0;
    end else begin
      opa = a_sh;
      sub = nr ? ~a[N] : 1'b1;
    end
  end

  // Next A:Q value
  always_comb begin
    aq_ld = 1'b0;
    a_in  = a;
    q_in  = q;
    if (acc) begin
      aq_ld = 1'b1;
      a_in  = {1'b0, dividend[2*N-1:N]};
      q_in  = dividend[N-1:0];
    end else begin
      case (st)
        ST_RUN: begin
          aq_ld = 1'b1;
          a_in  = (!nr && sum[N]) ? a_sh : sum;
          q_in  = {q[N-2:0], ~sum[N]};
        end
        ST_FIX: begin
          aq_ld = a[N];
          a_in  = sum;
        end
        default: ;
      endcase
    end
  end

  // Registered result outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      if (zhit) begin
        done        <= 1'b1;
        quotient    <= '1;
        remainder   <= dividend[N-1:0];
        div_by_zero <= 1'b1;
      end else if (st == ST_OUT) begin
        done        <= 1'b1;
        quotient    <= q;
        remainder   <= a[N-1:0];
        div_by_zero <= 1'b0;
      end
    end
  end

  assign busy = (st != ST_IDLE);

  // R1: reset clears all outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!busy && !done && !div_by_zero && quotient == '0 && remainder == '0));

  // R4: a restoring step never leaves a negative partial remainder
  a_r4_restore_nonneg: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && !nr) |=> !a[N]);

  // R5: after the correction cycle the partial remainder is non-negative
  a_r5_fix_nonneg: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OUT && nr) |-> !a[N]);

  // R6: zero divisor finishes in one cycle without going busy
  a_r6_zero_fast: assert property (@(posedge clk) disable iff (rst)
    zhit |=> (done && !busy && div_by_zero && quotient == '1));

  // R7: captured divisor is untouched while busy
  a_r7_div_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(d_r));

  // R8: results move only together with done
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

  // R9: normal completion clears the zero flag
  a_r9_flag_clear: assert property (@(posedge clk) disable iff (rst)
    (st == ST_OUT) |=> (done && !div_by_zero));

endmodule

// File: tb/seq_divider_tb_top.sv
module seq_divider_tb_top;

  localparam int N = 4;
  localparam int MASK = (1 << N) - 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic           mode = 1'b0;
  logic [2*N-1:0] dividend = '0;
  logic [N-1:0]   divisor = '0;
  logic           busy, done, div_by_zero;
  logic [N-1:0]   quotient, remainder;

  always #2 clk = ~clk;  // 250 MHz

  seq_divider #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .div_by_zero(div_by_zero)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;
  string ph = "R1";

  // Behavioural reference model
  bit m_busy = 0, m_done = 0, m_dbz = 0;
  int m_q = 0, m_r = 0, m_cnt = 0, p_q = 0, p_r = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_dbz = 0; m_q = 0; m_r = 0; m_cnt = 0;
    end else if (m_busy) begin
      m_done = 0;
      m_cnt  = m_cnt - 1;
      if (m_cnt == 0) begin
        m_busy = 0; m_done = 1; m_q = p_q; m_r = p_r; m_dbz = 0;
      end
    end else begin
      m_done = 0;
      if (start) begin
        if (divisor == 0) begin
          m_done = 1; m_dbz = 1; m_q = MASK; m_r = int'(dividend) & MASK;
        end else begin
          m_busy = 1;
          m_cnt  = mode ? N + 2 : N + 1;
          p_q    = int'(dividend) / int'(divisor);
          p_r    = int'(dividend) % int'(divisor);
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cmp_en) begin
      chk(ph, "busy", int'(busy), int'(m_busy));
      chk(ph, "done", int'(done), int'(m_done));
      chk(ph, "quotient", int'(quotient), m_q);
      chk(ph, "remainder", int'(remainder), m_r);
      chk(ph, "div_by_zero", int'(div_by_zero), int'(m_dbz));
    end
  end

  task automatic run_op(input bit md, input int x, input int dv, input string tag);
    @(negedge clk);
    ph = tag; start = 1'b1; mode = md;
    dividend = (2*N)'(x); divisor = N'(dv);
    @(negedge clk);
    start = 1'b0;
    dividend = '1; divisor = '1;
    repeat (N + 4) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "quotient", int'(quotient), 0);
    chk("R1", "div_by_zero", int'(div_by_zero), 0);
    rst = 1'b0;
    cmp_en = 1'b1;
    repeat (2) @(negedge clk);

    // R4: reference example in both modes
    run_op(1'b0, 32, 6, "R4");
    chk("R4", "restoring 32/6 q", int'(quotient), 5);
    chk("R4", "restoring 32/6 r", int'(remainder), 2);
    run_op(1'b1, 32, 6, "R4");
    chk("R4", "non-restoring 32/6 q", int'(quotient), 5);
    chk("R4", "non-restoring 32/6 r", int'(remainder), 2);

    // R2 / R3: boundary operands for timing in each mode
    run_op(1'b0, 0, 1, "R2");
    run_op(1'b0, (14 << N) | 15, 15, "R2");
    run_op(1'b1, 0, 1, "R3");
    run_op(1'b1, (14 << N) | 15, 15, "R3");
    run_op(1'b1, 15, 1, "R3");

    // R5: random valid operands, non-restoring; R4 random restoring
    for (int i = 0; i < 60; i++) begin
      int dv = $urandom_range(MASK, 1);
      int hi = $urandom_range(dv - 1, 0);
      int lo = $urandom_range(MASK, 0);
      run_op(1'b1, (hi << N) | lo, dv, "R5");
      run_op(1'b0, (hi << N) | lo, dv, "R4");
    end

    // R6: zero divisor, then R9: normal completion clears flag
    run_op(1'b0, 8'hA7, 0, "R6");
    chk("R6", "zero quotient", int'(quotient), MASK);
    chk("R6", "zero remainder", int'(remainder), 7);
    run_op(1'b1, 8'h3C, 0, "R6");
    run_op(1'b0, 45, 7, "R9");
    chk("R9", "flag cleared", int'(div_by_zero), 0);

    // R7: start pulses while busy are ignored
    @(negedge clk);
    ph = "R7"; start = 1'b1; mode = 1'b0; dividend = 8'd50; divisor = 4'd9;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; mode = 1'b1; dividend = 8'd13; divisor = 4'd0;
    @(negedge clk);
    start = 1'b1; dividend = 8'd99; divisor = 4'd11;
    @(negedge clk);
    start = 1'b0;
    repeat (N + 3) @(negedge clk);
    chk("R7", "original quotient kept", int'(quotient), 5);
    chk("R7", "original remainder kept", int'(remainder), 5);

    // R8: idle cycles with changing inputs and no start
    ph = "R8";
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      dividend = (2*N)'($urandom); divisor = N'($urandom); mode = ~mode;
    end

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule